// File: doc/BRIEF.md
# Multiplexed External Code-Fetch Bus Controller

This block supplies instruction bytes to a small 8-bit CPU core. A request carries a 16-bit program counter, and the block returns one code byte. The byte comes from one of two places. An on-chip program store is used when the strap input `int_code_sel` is high. An external program memory is used when the strap is low. The external memory is reached over a multiplexed bus. The low byte of the bus carries the address first and then the data. A separate high byte carries the upper address bits.

An external fetch runs through four one-clock phases:

1. Address drive, with the latch strobe `ale` high.
2. Address hold, with `ale` low.
3. Float, with the low port released.
4. Read strobe, with `psen_n` low.

The code byte is captured at the end of the strobe phase. On the next cycle it is returned with a one-cycle `rsp_valid` pulse. An internal fetch does not touch the bus pins. It returns its byte on the cycle after acceptance and can be issued every cycle.

Request side: a fetch is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls for the whole external sequence, and this is the only back-pressure. The response side has no ready signal. The consumer must take `rsp_byte` in the cycle where `rsp_valid` is high. When no external fetch is in progress, the low and high bus ports carry the general-purpose values from `gp_lo_out`, `gp_lo_oe` and `gp_hi_out`.

Top module: `codefetch_ctrl`

## Requirements
- R1: During and right after reset: `rsp_valid` is 0, `ale` is 0, `psen_n` is 1 and `req_ready` is 1. The bus ports show the general-purpose values.
- R2: With `int_code_sel` high, an accepted request gives `rsp_valid`=1 on the next cycle. The byte is `pc[7:0] ^ pc[15:8] ^ 8'h5A`. `req_ready` stays high, so one fetch can be accepted every cycle.
- R3: During internal fetches, `psen_n` stays 1 and `ale` stays 0. `bus_lo_out`, `bus_lo_oe` and `bus_hi_out` equal `gp_lo_out`, `gp_lo_oe` and `gp_hi_out`.
- R4: After an external request is accepted, the phases run one clock each:
  - cycle 1: `ale`=1, `bus_lo_oe`=1, `bus_lo_out`=pc[7:0]
  - cycle 2: `ale`=0, with the same low address still driven
  - cycle 3: `bus_lo_oe`=0, `psen_n`=1
  - cycle 4: `psen_n`=0, `bus_lo_oe`=0
  - cycle 5: `psen_n`=1 and `rsp_valid`=1
- R5: `bus_hi_out` equals pc[15:8] for all four external phases.
- R6: An external response byte is the value on `bus_lo_in` at the clock edge that ends the strobe phase, while `psen_n` is 0. The on-chip store is not used.
- R7: `req_ready` is 0 from the cycle after an external acceptance through the strobe phase. A `req_valid` raised during that time starts nothing, and its address never reaches the bus.
- R8: `ale` and `psen_n` each stay active for exactly one clock per fetch. `psen_n` is never low while the low port drives, or in the cycle right after it drove.
- R9: The fetch source is taken from `int_code_sel` at acceptance. A change on the strap during an external fetch does not alter that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_code_sel | input | 1 | Strap input: 1 selects the on-chip code store, 0 selects external memory |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block can accept a fetch request |
| req_pc | input | 16 | Program counter of the requested byte |
| rsp_valid | output | 1 | One-cycle pulse that marks `rsp_byte` as valid |
| rsp_byte | output | 8 | Fetched code byte |
| gp_lo_out | input | 8 | General-purpose value for the low port when the bus is idle |
| gp_lo_oe | input | 1 | General-purpose output enable for the low port |
| gp_hi_out | input | 8 | General-purpose value for the high port when the bus is idle |
| bus_lo_out | output | 8 | Low port drive value (address, then released) |
| bus_lo_oe | output | 1 | Low port output enable; 0 means high impedance |
| bus_lo_in | input | 8 | Value read back from the low port pins |
| bus_hi_out | output | 8 | High port value (upper address bits during a fetch) |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program store read strobe, active low |

## Verification
The assertions assume two things. First, reset is held for at least one clock before the first request. Second, `rsp_valid` follows an internal acceptance only when the strap was high at that edge. The bench changes inputs only on falling clock edges, and it raises `int_code_sel` mid-fetch only in the dedicated R9 case. The external memory model in the bench drives the real code byte only while `psen_n` is low and a marker value otherwise. A capture at the wrong edge therefore shows up as a wrong byte.

// File: rtl/codefetch_pkg.sv
package codefetch_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_HOLD   = 3'd2,
    PH_FLOAT  = 3'd3,
    PH_STROBE = 3'd4
  } phase_e;
endpackage

// File: rtl/cf_int_rom.sv
// On-chip code store: content is a fold of the address slices with a key.
module cf_int_rom #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY = 8'h5A
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int NSL = AW / DW;

  logic [DW-1:0] fold;

  always_comb begin
    fold = KEY;
    for (int i = 0; i < NSL; i++) begin
      fold = fold ^ addr[i*DW +: DW];
    end
  end

  // the store is gated off when external code is selected
  assign data = en ? fold : '0;
endmodule

// File: rtl/cf_ext_seq.sv
// Phase sequencer for one external code fetch; strobes are registered.
module cf_ext_seq
  import codefetch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   ale,
  output logic   psen_n,
  output logic   done
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start) phase_d = PH_ADDR;
      PH_ADDR:   phase_d = PH_HOLD;
      PH_HOLD:   phase_d = PH_FLOAT;
      PH_FLOAT:  phase_d = PH_STROBE;
      PH_STROBE: phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ale     <= 1'b0;
      psen_n  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      ale     <= (phase_d == PH_ADDR);
      psen_n  <= (phase_d != PH_STROBE);
    end
  end

  assign phase = phase_q;
  assign done  = (phase_q == PH_STROBE);
endmodule

// File: rtl/cf_port_mux.sv
// Selects between fetch-cycle drive and general-purpose drive on both ports.
module cf_port_mux
  import codefetch_pkg::*;
#(
  parameter int DW = 8
) (
  input  phase_e        phase,
  input  logic [DW-1:0] addr_lo,
  input  logic [DW-1:0] addr_hi,
  input  logic [DW-1:0] gp_lo_out,
  input  logic          gp_lo_oe,
  input  logic [DW-1:0] gp_hi_out,
  output logic [DW-1:0] bus_lo_out,
  output logic          bus_lo_oe,
  output logic [DW-1:0] bus_hi_out
);
  always_comb begin
    bus_lo_out = gp_lo_out;
    bus_lo_oe  = gp_lo_oe;
    bus_hi_out = gp_hi_out;
    unique case (phase)
      PH_ADDR, PH_HOLD: begin
        bus_lo_out = addr_lo;
        bus_lo_oe  = 1'b1;
        bus_hi_out = addr_hi;
      end
      PH_FLOAT, PH_STROBE: begin
        bus_lo_out = addr_lo;
        bus_lo_oe  = 1'b0;
        bus_hi_out = addr_hi;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/codefetch_ctrl.sv
module codefetch_ctrl
  import codefetch_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] ROM_KEY = 8'h5A,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_code_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_pc,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_byte,
  input  logic [DW-1:0] gp_lo_out,
  input  logic          gp_lo_oe,
  input  logic [DW-1:0] gp_hi_out,
  output logic [DW-1:0] bus_lo_out,
  output logic          bus_lo_oe,
  input  logic [DW-1:0] bus_lo_in,
  output logic [DW-1:0] bus_hi_out,
  output logic          ale,
  output logic          psen_n
);
  phase_e        phase;
  logic          accept, start_ext, ext_done;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] rom_data;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign start_ext = accept && !int_code_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (start_ext)  pc_q <= req_pc;
  end

  cf_int_rom #(.AW(AW), .DW(DW), .KEY(ROM_KEY)) u_rom (
    .en   (int_code_sel),
    .addr (req_pc),
    .data (rom_data)
  );

  cf_ext_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_ext),
    .phase  (phase),
    .ale    (ale),
    .psen_n (psen_n),
    .done   (ext_done)
  );

  cf_port_mux #(.DW(DW)) u_mux (
    .phase      (phase),
    .addr_lo    (pc_q[DW-1:0]),
    .addr_hi    (pc_q[AW-1:DW]),
    .gp_lo_out  (gp_lo_out),
    .gp_lo_oe   (gp_lo_oe),
    .gp_hi_out  (gp_hi_out),
    .bus_lo_out (bus_lo_out),
    .bus_lo_oe  (bus_lo_oe),
    .bus_hi_out (bus_hi_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_byte  <= '0;
    end else begin
      rsp_valid <= ext_done || (accept && int_code_sel);
      if (ext_done)                     rsp_byte <= bus_lo_in;
      else if (accept && int_code_sel)  rsp_byte <= rom_data;
    end
  end
endmodule

// File: rtl/codefetch_ctrl_chk.sv
module codefetch_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_code_sel,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] bus_lo_out,
  input logic          bus_lo_oe,
  input logic [DW-1:0] bus_hi_out,
  input logic          ale,
  input logic          psen_n
);
  // R2
  int_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && int_code_sel |=> rsp_valid);

  // R4
  addr_held_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> bus_lo_oe && $stable(bus_lo_out));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !bus_lo_oe && !$past(bus_lo_oe));

  // R8
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R8
  psen_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |=> psen_n);

  // R5
  hi_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> $stable(bus_hi_out));

  // R6
  rsp_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psen_n) |-> rsp_valid);

  // R7
  strobes_idle_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> psen_n && !ale);
endmodule

bind codefetch_ctrl codefetch_ctrl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .int_code_sel (int_code_sel),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .bus_lo_out   (bus_lo_out),
  .bus_lo_oe    (bus_lo_oe),
  .bus_hi_out   (bus_hi_out),
  .ale          (ale),
  .psen_n       (psen_n)
);

// File: tb/codefetch_ctrl_bench.sv
module codefetch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_code_sel = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_pc = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_byte;
  logic [7:0]  gp_lo_out = 8'h3C;
  logic        gp_lo_oe = 1'b1;
  logic [7:0]  gp_hi_out = 8'hC3;
  logic [7:0]  bus_lo_out;
  logic        bus_lo_oe;
  logic [7:0]  bus_lo_in;
  logic [7:0]  bus_hi_out;
  logic        ale;
  logic        psen_n;
  logic [7:0]  ext_byte = 8'h00;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  // external memory model: real byte only while the read strobe is low
  assign bus_lo_in = !psen_n ? ext_byte : 8'hEE;

  codefetch_ctrl u_codefetch_ctrl (
    .clk(clk), .rst_n(rst_n), .int_code_sel(int_code_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .gp_lo_out(gp_lo_out), .gp_lo_oe(gp_lo_oe), .gp_hi_out(gp_hi_out),
    .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_lo_in(bus_lo_in),
    .bus_hi_out(bus_hi_out), .ale(ale), .psen_n(psen_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] int_byte(input logic [15:0] pc);
    return pc[7:0] ^ pc[15:8] ^ 8'h5A;
  endfunction

  task automatic idle_ports(input string tag);
    chk({tag, " lo_out gp"}, bus_lo_out, gp_lo_out);
    chk({tag, " lo_oe gp"},  bus_lo_oe,  gp_lo_oe);
    chk({tag, " hi_out gp"}, bus_hi_out, gp_hi_out);
    chk({tag, " psen_n"},    psen_n,     1'b1);
    chk({tag, " ale"},       ale,        1'b0);
  endtask

  task automatic fetch(input logic sel, input logic [15:0] pc, input logic [7:0] d);
    @(negedge clk);
    int_code_sel = sel; req_pc = pc; req_valid = 1'b1; ext_byte = d;
    chk("R7 ready before request", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    if (sel) begin
      chk("R2 internal valid", rsp_valid, 1'b1);
      chk("R2 internal byte", rsp_byte, int_byte(pc));
      idle_ports("R3");
    end else begin
      chk("R4 addr ale", ale, 1'b1);
      chk("R4 addr oe", bus_lo_oe, 1'b1);
      chk("R4 addr lo", bus_lo_out, pc[7:0]);
      chk("R5 addr hi", bus_hi_out, pc[15:8]);
      chk("R7 busy ready", req_ready, 1'b0);
      @(negedge clk);
      chk("R4 hold ale", ale, 1'b0);
      chk("R4 hold oe", bus_lo_oe, 1'b1);
      chk("R4 hold lo", bus_lo_out, pc[7:0]);
      @(negedge clk);
      chk("R4 float oe", bus_lo_oe, 1'b0);
      chk("R4 float psen_n", psen_n, 1'b1);
      chk("R5 float hi", bus_hi_out, pc[15:8]);
      @(negedge clk);
      chk("R4 strobe psen_n", psen_n, 1'b0);
      chk("R4 strobe oe", bus_lo_oe, 1'b0);
      chk("R5 strobe hi", bus_hi_out, pc[15:8]);
      @(negedge clk);
      chk("R4 rsp valid", rsp_valid, 1'b1);
      chk("R6 ext byte", rsp_byte, d);
      idle_ports("R4 end");
    end
    @(negedge clk);
    chk("R8 rsp single pulse", rsp_valid, 1'b0);
  endtask

  // {int_code_sel, pc, external byte}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 16'h0000, 8'h11},
    {1'b1, 16'h0000, 8'h00},
    {1'b0, 16'hFFFF, 8'hA7},
    {1'b1, 16'hFFFF, 8'h00},
    {1'b0, 16'h12F0, 8'h00},
    {1'b1, 16'hA55A, 8'h00},
    {1'b0, 16'h00FF, 8'hFF},
    {1'b1, 16'hFF00, 8'h00}
  };

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 rsp_valid in reset", rsp_valid, 1'b0);
    chk("R1 ready in reset", req_ready, 1'b1);
    idle_ports("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 1'b0);
    idle_ports("R1 after reset");

    for (int i = 0; i < 8; i++) begin
      fetch(VEC[i][24], VEC[i][23:8], VEC[i][7:0]);
    end

    // R2 back-to-back internal fetches
    @(negedge clk);
    int_code_sel = 1'b1; req_valid = 1'b1; req_pc = 16'h0100;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R2 stream valid", rsp_valid, 1'b1);
      chk("R2 stream byte", rsp_byte, int_byte(16'h0100 + 16'(k - 1)));
      chk("R2 stream ready", req_ready, 1'b1);
      idle_ports("R3 stream");
      req_pc = 16'h0100 + 16'(k);
    end
    req_valid = 1'b0;
    @(negedge clk);

    // R3 idle ports follow general-purpose changes
    gp_lo_out = 8'h96; gp_lo_oe = 1'b0; gp_hi_out = 8'h69;
    fetch(1'b1, 16'h0042, 8'h00);

    // R7 requests during an external fetch are ignored
    @(negedge clk);
    int_code_sel = 1'b0; req_pc = 16'h2345; req_valid = 1'b1; ext_byte = 8'h5C;
    @(negedge clk);
    req_pc = 16'hBEEF;
    chk("R7 addr uses accepted pc", bus_lo_out, 8'h45);
    @(negedge clk);
    chk("R7 hold keeps first pc", bus_lo_out, 8'h45);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 ready low in float", req_ready, 1'b0);
    @(negedge clk);
    chk("R7 hi keeps first pc", bus_hi_out, 8'h23);
    @(negedge clk);
    chk("R7 rsp byte", rsp_byte, 8'h5C);
    repeat (3) begin
      @(negedge clk);
      chk("R7 no extra fetch ale", ale, 1'b0);
      chk("R7 no extra rsp", rsp_valid, 1'b0);
    end

    // R9 strap change mid-fetch does not alter the fetch
    @(negedge clk);
    int_code_sel = 1'b0; req_pc = 16'h7788; req_valid = 1'b1; ext_byte = 8'h3D;
    @(negedge clk);
    req_valid = 1'b0; int_code_sel = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R9 strobe still issued", psen_n, 1'b0);
    @(negedge clk);
    chk("R9 rsp valid", rsp_valid, 1'b1);
    chk("R9 rsp external byte", rsp_byte, 8'h3D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule